// File: doc/BRIEF.md
# Synchronized Clock Stop Gate

This block gates a group of clock outputs that share one source clock. An asynchronous, active-low stop request brings the outputs to rest at logic 0 and releases them later, with no shortened pulse in either direction. The request is passed through a two-flop synchronizer in the clock's own domain. The final enable for each output is held in a flop that loads on the falling edge, so an output can only begin or end a pulse at a whole clock phase.

Each output also has a static enable. Output 0 is built to ignore stop requests. The highest output can be made to ignore them by a control input. One pin is shared and its role depends on the mode input. In mobile mode it is the stop-request input. In desktop mode it is an extra clock output, and stop requests are then ignored.

Top module: `clk_stop_gate`

## Requirements
- R1: While `rst_n` is low, every bit of `clk_out` and `pin_out` is 0.
- R2: With `mode_mobile`=1, when `pin_in` falls, the stoppable enabled outputs give a high phase after the first two rising clock edges that follow. They are low from the third rising edge onward, so the off latency is under 4 cycles.
- R3: While a stop is in force, each stoppable output stays at 0 through both clock phases.
- R4: When `pin_in` rises again, stopped outputs stay low after the first two rising edges. They resume at the third rising edge, and the first high phase is full width.
- R5: Output 0 is free running: stop requests never affect it.
- R6: With `free_run_sel`=1, output NUM_OUT-1 (bit 3 by default) keeps running during a stop.
- R7: An output whose `out_en` bit is 0 is held low, starting from the second rising edge after the change. A bit of 1 lets the output run, and a bench setting of all ones is the default.
- R8: With `mode_mobile`=0, `pin_oe` is 1 and `pin_out` carries the clock when `spare_en`=1 and is 0 when `spare_en`=0. `pin_in` is ignored, so no stop takes effect.
- R9: With `mode_mobile`=1, `pin_oe` is 0 and `pin_out` stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Source clock for the group |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_mobile | input | 1 | 1 = the shared pin is the stop input; 0 = it is an extra clock output |
| pin_in | input | 1 | Level seen on the shared pin; active-low stop request in mobile mode |
| out_en | input | NUM_OUT | Static per-output enable, 1 = running |
| free_run_sel | input | 1 | Makes output NUM_OUT-1 ignore stop requests |
| spare_en | input | 1 | Enable for the shared pin when it is used as a clock output |
| clk_out | output | NUM_OUT | Gated clock outputs |
| pin_out | output | 1 | Clock driven onto the shared pin |
| pin_oe | output | 1 | Output enable for the shared pin |

## Verification
A stop or release edge on the pin reaches the outputs after three registers: two synchronizer flops on rising edges, then the falling-edge enable flop. The outputs therefore change in the high phase after the third rising edge that follows the request. Enable and mode changes pass through only the falling-edge flop and take effect from the second rising edge. The bench changes inputs at several offsets within a cycle. It then samples each high phase 0.5 ns and 1.5 ns after the rising edge, and each low phase 3 ns after it, so every check falls inside a stable phase at a precise edge count.

// File: rtl/clk_stop_gate.sv
module clk_stop_gate #(
  parameter int NUM_OUT = 4,
  parameter logic [NUM_OUT-1:0] FIXED_FREE = NUM_OUT'(1),
  parameter int PROG_FREE_IDX = NUM_OUT - 1
) (
  input  logic               clk_in,
  input  logic               rst_n,
  input  logic               mode_mobile,
  input  logic               pin_in,
  input  logic [NUM_OUT-1:0] out_en,
  input  logic               free_run_sel,
  input  logic               spare_en,
  output logic [NUM_OUT-1:0] clk_out,
  output logic               pin_out,
  output logic               pin_oe
);

  logic               run_req;
  logic [1:0]         sync_q;
  logic [NUM_OUT-1:0] free_vec;
  logic [NUM_OUT-1:0] gate_d;
  logic [NUM_OUT-1:0] gate_q;
  logic               spare_q;
  logic               stop_act;

  assign run_req  = ~mode_mobile | pin_in;
  assign stop_act = ~run_req;
  assign free_vec = FIXED_FREE | ({{(NUM_OUT-1){1'b0}}, free_run_sel} << PROG_FREE_IDX);
  assign gate_d   = out_en & ({NUM_OUT{sync_q[1]}} | free_vec);

  always_ff @(posedge clk_in or negedge rst_n)
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], run_req};

  always_ff @(negedge clk_in or negedge rst_n)
    if (!rst_n) begin
      gate_q  <= '0;
      spare_q <= 1'b0;
    end else begin
      gate_q  <= gate_d;
      spare_q <= ~mode_mobile & spare_en;
    end

  assign clk_out = {NUM_OUT{clk_in}} & gate_q;
  assign pin_out = clk_in & spare_q;
  assign pin_oe  = ~mode_mobile;

  AST_OFF_LATENCY: assert property (@(negedge clk_in) disable iff (!rst_n)
    ($past(rst_n,3) && $past(stop_act,3) && $past(stop_act,2) && $past(stop_act,1) && stop_act)
    |-> ((clk_out & ~$past(free_vec)) == '0)); // R2

  AST_ON_LATENCY: assert property (@(negedge clk_in) disable iff (!rst_n)
    ($past(rst_n,3) && $past(run_req,3) && $past(run_req,2) && $past(run_req,1) && run_req)
    |-> (clk_out == $past(out_en))); // R4

  AST_FREE_RUN: assert property (@(negedge clk_in) disable iff (!rst_n)
    $past(rst_n) |-> ((clk_out & $past(out_en & free_vec)) == $past(out_en & free_vec))); // R5

  AST_DISABLED_LOW: assert property (@(negedge clk_in) disable iff (!rst_n)
    $past(rst_n) |-> ((clk_out & ~$past(out_en)) == '0)); // R7

  AST_PIN_QUIET: assert property (@(negedge clk_in) disable iff (!rst_n)
    ($past(rst_n) && $past(mode_mobile)) |-> !pin_out); // R9

endmodule

// File: tb/clk_stop_gate_bench.sv
`timescale 1ns/100ps
module clk_stop_gate_bench;
  localparam int N = 4;
  logic clk_in = 0, rst_n = 0, mode_mobile = 1, pin_in = 1, free_run_sel = 0, spare_en = 0;
  logic [N-1:0] out_en = '1;
  logic [N-1:0] clk_out;
  logic pin_out, pin_oe;
  int total = 0, bad = 0;

  clk_stop_gate #(.NUM_OUT(N)) u_clk_stop_gate (
    .clk_in(clk_in), .rst_n(rst_n), .mode_mobile(mode_mobile), .pin_in(pin_in),
    .out_en(out_en), .free_run_sel(free_run_sel), .spare_en(spare_en),
    .clk_out(clk_out), .pin_out(pin_out), .pin_oe(pin_oe));

  always #2 clk_in = ~clk_in;

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset();
    for (int k = 0; k < 4; k++) begin
      #1.3; chk("R1 clk_out", clk_out, '0); chk("R1 pin_out", N'(pin_out), '0);
    end
    @(negedge clk_in); #1 rst_n = 1;
    repeat (3) @(posedge clk_in);
    #1 chk("R7 default run", clk_out, '1);
  endtask

  task automatic t_stop(input real off, input logic [N-1:0] keep);
    @(posedge clk_in); #(off) pin_in = 0;
    for (int k = 0; k < 6; k++) begin
      @(posedge clk_in); #1;
      chk("R2 off latency", clk_out, (k < 2) ? '1 : keep);
      #2 chk("R3 parked low", clk_out, '0);
    end
    repeat (12) @(posedge clk_in);
    #1 chk("R3 still parked", clk_out, keep);
  endtask

  task automatic t_start(input real off, input logic [N-1:0] keep);
    @(posedge clk_in); #(off) pin_in = 1;
    for (int k = 0; k < 6; k++) begin
      @(posedge clk_in); #0.5;
      chk("R4 restart early", clk_out, (k < 2) ? keep : '1);
      #1 chk("R4 full width", clk_out, (k < 2) ? keep : '1);
      #1.5 chk("R4 low phase", clk_out, '0);
    end
    repeat (100) @(posedge clk_in);
  endtask

  task automatic t_enable();
    @(negedge clk_in); #1 out_en = 4'b1101;
    @(posedge clk_in); #1 chk("R7 old value", clk_out, '1);
    @(posedge clk_in); #1 chk("R7 disabled low", clk_out, 4'b1101);
    @(negedge clk_in); #1 out_en = '1;
    repeat (2) @(posedge clk_in); #1 chk("R7 re-enabled", clk_out, '1);
  endtask

  task automatic t_desktop();
    @(negedge clk_in); #1 begin mode_mobile = 0; spare_en = 1; pin_in = 0; end
    repeat (6) @(posedge clk_in);
    #1 begin
      chk("R8 pin_oe", N'(pin_oe), N'(1));
      chk("R8 stop ignored", clk_out, '1);
      chk("R8 pin_out high", N'(pin_out), N'(1));
    end
    #2 chk("R8 pin_out low", N'(pin_out), '0);
    @(negedge clk_in); #1 spare_en = 0;
    repeat (2) @(posedge clk_in); #1 chk("R8 spare off", N'(pin_out), '0);
    @(negedge clk_in); #1 begin pin_in = 1; mode_mobile = 1; end
    repeat (3) @(posedge clk_in);
    #1 begin
      chk("R9 pin_oe", N'(pin_oe), '0);
      chk("R9 pin_out", N'(pin_out), '0);
      chk("R9 outputs run", clk_out, '1);
    end
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    repeat (100) @(posedge clk_in);
    t_stop(0.7, 4'b0001);  t_start(1.3, 4'b0001);   // R5 output 0 free
    t_stop(2.5, 4'b0001);  t_start(3.6, 4'b0001);
    @(negedge clk_in); #1 free_run_sel = 1;
    repeat (3) @(posedge clk_in);
    t_stop(1.7, 4'b1001);  t_start(0.6, 4'b1001);   // R6
    @(negedge clk_in); #1 free_run_sel = 0;
    repeat (3) @(posedge clk_in);
    t_enable();
    t_desktop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule